// File: doc/BRIEF.md
# Serial MSB-first fuzzy membership evaluator

This block computes the degree of membership of an unsigned sample in one of several trapezoidal fuzzy sets. The sample arrives one bit per accepted transfer, most significant bit first. The membership degree is a small integer level, also sent out most significant bit first. Each output bit leaves as soon as the input bits received so far fix it, so a result can finish before the whole sample has arrived.

Internally the received prefix is held as a node of a binary tree. The root is node 1, and each accepted bit moves to node `2*node + bit`. For every node the block knows the range of full samples that still match it. An output bit is fixed at a node when every sample in that range gives the same value for that bit. The trapezoid levels are computed at elaboration from corner points, scaled by `2**LEVEL_W - 1` and rounded to the nearest integer. A start strobe begins each evaluation and selects the function. The output is a valid/ready stream that holds its data while the consumer stalls. The input stream only refuses data in the cycle of a start strobe.

Top module: `msm_serial_membership`

## Requirements
- R1: `in_ready` equals `!start`. A bit is taken when `in_valid && in_ready`. Each taken bit moves the node from `v` to `2*v + in_bit`, up to `DATA_W` bits per evaluation.
- R2: Output bit j (j = 0 is the MSB) is fixed at a node when every sample whose top bits equal the node's prefix gives the same bit j. That bit is offered with `out_valid` in the first cycle after the node is reached in which all higher bits have been taken. No output bit is offered earlier.
- R3: Exactly `LEVEL_W` output bits are delivered per evaluation, one per `out_valid && out_ready` transfer, MSB first. Together they form the membership level of the full sample.
- R4: While `out_valid` is high and `out_ready` is low (and no start), `out_valid` stays high and `out_bit` stays unchanged into the next cycle.
- R5: A start pulse returns to node 1, restarts the output sequence, clears `done` and latches `fn_sel`. An input bit offered in the same cycle is not taken.
- R6: An input bit offered after every output bit has been fixed, or after `DATA_W` bits have been taken, changes no output.
- R7: `done` rises in the cycle after the last output transfer and stays high until the next start. `out_valid` is low while `done` is high.
- R8: With DATA_W = 6 and LEVEL_W = 3 (scale 7), the selector codes give trapezoids with corners (a,b,c,d) as follows: 0 → (0,0,10,26), 1 → (10,24,30,44), 2 → (30,40,44,56), 3 → (40,54,63,63). The level is 7 for b ≤ x ≤ c. Otherwise it is 0 for x ≤ a or x ≥ d. On the rising edge it is floor((14(x−a)+(b−a)) / (2(b−a))), and on the falling edge it is floor((14(d−x)+(d−c)) / (2(d−c))).
- R9: After a synchronous active-low reset the block behaves as if a start had been received with selector code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a new evaluation |
| fn_sel | input | SEL_W | Membership function code, sampled with start |
| in_valid | input | 1 | Input bit offered |
| in_ready | output | 1 | Input bit can be taken |
| in_bit | input | 1 | Serial sample bit, MSB first |
| out_valid | output | 1 | Output bit offered |
| out_ready | input | 1 | Consumer takes the output bit |
| out_bit | output | 1 | Serial membership bit, MSB first |
| done | output | 1 | All output bits of this evaluation delivered |

## Verification
A wrong tree node or a wrong agreement decision shows up at the ports as an output bit offered one or more cycles too early or too late. The cycle-by-cycle comparison against a brute-force search over the matching samples catches such a bit in the cycle it goes wrong. A wrong level table or a wrong emit pointer shows up as a bad bit value or as out-of-order bits. This is caught on the first transfer it affects, and again by the final assembled level. The samples are swept over every value of every selector code, with and without consumer stalls, so every tree edge is walked.

// File: rtl/msm_pkg.sv
package msm_pkg;

  // Corner points of the trapezoids on a 0..63 grid; code f picks set f mod 4.
  function automatic int trap_corner(int f, int idx);
    int t [4];
    case (f % 4)
      0: t = '{0, 0, 10, 26};
      1: t = '{10, 24, 30, 44};
      2: t = '{30, 40, 44, 56};
      default: t = '{40, 54, 63, 63};
    endcase
    return t[idx];
  endfunction

  // Scaled, rounded membership level of sample x for set f.
  function automatic int mu_level(int f, int x, int n, int s);
    int m, a, b, c, d;
    m = (1 << n) - 1;
    a = trap_corner(f, 0) * m / 63;
    b = trap_corner(f, 1) * m / 63;
    c = trap_corner(f, 2) * m / 63;
    d = trap_corner(f, 3) * m / 63;
    if (x >= b && x <= c) return s;
    if (x <= a || x >= d) return 0;
    if (x < b) return (2 * s * (x - a) + (b - a)) / (2 * (b - a));
    return (2 * s * (d - x) + (d - c)) / (2 * (d - c));
  endfunction

endpackage

// File: rtl/msm_level_table.sv
module msm_level_table #(
  parameter int DATA_W  = 6,
  parameter int LEVEL_W = 3,
  parameter int NUM_FN  = 4,
  parameter int SEL_W   = 2
) (
  input  logic [SEL_W-1:0]                   sel,
  output logic [(1<<DATA_W)-1:0][LEVEL_W-1:0] lvl
);
  localparam int LEAVES = 1 << DATA_W;
  localparam int SCALE  = (1 << LEVEL_W) - 1;

  logic [NUM_FN-1:0][LEAVES-1:0][LEVEL_W-1:0] tbl;

  for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
    for (genvar x = 0; x < LEAVES; x++) begin : g_leaf
      localparam int LV = msm_pkg::mu_level(f, x, DATA_W, SCALE);
      assign tbl[f][x] = LEVEL_W'(LV);
    end
  end

  always_comb begin
    lvl = tbl[0];
    for (int f = 0; f < NUM_FN; f++) begin
      if (SEL_W'(f) == sel) lvl = tbl[f];
    end
  end
endmodule

// File: rtl/msm_span_agree.sv
module msm_span_agree #(
  parameter int DATA_W  = 6,
  parameter int LEVEL_W = 3
) (
  input  logic [DATA_W:0]                     node,
  input  logic [(1<<DATA_W)-1:0][LEVEL_W-1:0] lvl,
  output logic [LEVEL_W-1:0]                  fixed,
  output logic [LEVEL_W-1:0]                  value
);
  localparam int LEAVES = 1 << DATA_W;

  int depth, lo, hi;
  logic [LEVEL_W-1:0] all_one, any_one;

  always_comb begin
    depth = 0;
    for (int b = 0; b <= DATA_W; b++) begin
      if (node[b]) depth = b;
    end
    lo = (int'(node) - (1 << depth)) << (DATA_W - depth);
    hi = lo + (1 << (DATA_W - depth)) - 1;
    all_one = '1;
    any_one = '0;
    for (int i = 0; i < LEAVES; i++) begin
      if (i >= lo && i <= hi) begin
        all_one = all_one & lvl[i];
        any_one = any_one | lvl[i];
      end
    end
    fixed = all_one | ~any_one;
    value = all_one;
  end
endmodule

// File: rtl/msm_tree_walk.sv
module msm_tree_walk #(
  parameter int DATA_W = 6,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEL_W-1:0]  fn_sel,
  input  logic              take,
  input  logic              in_bit,
  input  logic              settled,
  output logic [DATA_W:0]   node,
  output logic [SEL_W-1:0]  sel_q
);
  logic step;
  assign step = take && !settled && !node[DATA_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      node  <= (DATA_W+1)'(1);
      sel_q <= '0;
    end else if (start) begin
      node  <= (DATA_W+1)'(1);
      sel_q <= fn_sel;
    end else if (step) begin
      node  <= {node[DATA_W-1:0], in_bit};
    end
  end
endmodule

// File: rtl/msm_emit.sv
module msm_emit #(
  parameter int LEVEL_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LEVEL_W-1:0] fixed,
  input  logic [LEVEL_W-1:0] value,
  input  logic               out_ready,
  output logic               out_valid,
  output logic               out_bit,
  output logic               done
);
  localparam int PW = $clog2(LEVEL_W + 1);
  logic [PW-1:0] ptr;

  always_comb begin
    out_valid = 1'b0;
    out_bit   = 1'b0;
    for (int j = 0; j < LEVEL_W; j++) begin
      if (PW'(j) == ptr) begin
        out_valid = fixed[LEVEL_W-1-j];
        out_bit   = value[LEVEL_W-1-j];
      end
    end
  end

  assign done = (ptr == PW'(LEVEL_W));

  always_ff @(posedge clk) begin
    if (!rst_n || start) ptr <= '0;
    else if (out_valid && out_ready) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/msm_serial_membership.sv
module msm_serial_membership #(
  parameter int DATA_W  = 6,
  parameter int LEVEL_W = 3,
  parameter int NUM_FN  = 4,
  parameter int SEL_W   = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] fn_sel,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_bit,
  output logic             done
);
  logic [DATA_W:0]                     node;
  logic [SEL_W-1:0]                    sel_q;
  logic [(1<<DATA_W)-1:0][LEVEL_W-1:0] lvl;
  logic [LEVEL_W-1:0]                  fixed, value;

  assign in_ready = !start;

  msm_level_table #(.DATA_W(DATA_W), .LEVEL_W(LEVEL_W), .NUM_FN(NUM_FN), .SEL_W(SEL_W)) u_table (
    .sel(sel_q), .lvl(lvl)
  );

  msm_span_agree #(.DATA_W(DATA_W), .LEVEL_W(LEVEL_W)) u_agree (
    .node(node), .lvl(lvl), .fixed(fixed), .value(value)
  );

  msm_tree_walk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .fn_sel(fn_sel),
    .take(in_valid && in_ready), .in_bit(in_bit), .settled(&fixed),
    .node(node), .sel_q(sel_q)
  );

  msm_emit #(.LEVEL_W(LEVEL_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .start(start), .fixed(fixed), .value(value),
    .out_ready(out_ready), .out_valid(out_valid), .out_bit(out_bit), .done(done)
  );
endmodule

// File: rtl/msm_serial_membership_chk.sv
module msm_serial_membership_chk #(
  parameter int LEVEL_W = 3
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic done
);
  logic [7:0] sent;
  always_ff @(posedge clk) begin
    if (!rst_n || start) sent <= '0;
    else if (out_valid && out_ready) sent <= sent + 1'b1;
  end

  a_r4_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !start |=> out_valid && $stable(out_bit));

  a_r5_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  a_r7_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  a_r3_exact_count: assert property (@(posedge clk) disable iff (!rst_n)
    (sent == 8'(LEVEL_W)) |-> !out_valid && done);
endmodule

bind msm_serial_membership msm_serial_membership_chk #(.LEVEL_W(LEVEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .out_valid(out_valid),
  .out_ready(out_ready), .out_bit(out_bit), .done(done)
);

// File: tb/msm_serial_membership_tb.sv
module msm_serial_membership_tb;
  localparam int N = 6;
  localparam int L = 3;

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0, in_bit = 0, out_ready = 0;
  logic [1:0] fn_sel = 0;
  logic in_ready, out_valid, out_bit, done;
  int checks = 0, errors = 0;

  // reference state
  int r_sel = 0, r_k = 0, r_pre = 0, r_e = 0;
  int got;

  always #5 clk = ~clk;

  msm_serial_membership u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fn_sel(fn_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit), .done(done)
  );

  // R8: level from the trapezoid definition
  function automatic int ref_mu(int f, int x);
    int a, b, c, d;
    case (f)
      0: begin a = 0;  b = 0;  c = 10; d = 26; end
      1: begin a = 10; b = 24; c = 30; d = 44; end
      2: begin a = 30; b = 40; c = 44; d = 56; end
      default: begin a = 40; b = 54; c = 63; d = 63; end
    endcase
    if (x >= b && x <= c) return 7;
    if (x <= a || x >= d) return 0;
    if (x < b) return (14 * (x - a) + (b - a)) / (2 * (b - a));
    return (14 * (d - x) + (d - c)) / (2 * (d - c));
  endfunction

  // R2: is output bit j settled for samples matching the received prefix
  function automatic bit ref_fixed(int j, output bit v);
    bit seen0 = 0, seen1 = 0;
    for (int x = 0; x < (1 << N); x++) begin
      if ((x >> (N - r_k)) == r_pre || r_k == 0) begin
        if ((ref_mu(r_sel, x) >> (L - 1 - j)) & 1) seen1 = 1; else seen0 = 1;
      end
    end
    v = seen1;
    return !(seen0 && seen1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, compare, advance reference across the posedge.
  task automatic step(bit st, bit iv, bit ib, bit rdy, int fsel);
    bit ev, eb, all_fixed, v;
    start = st; in_valid = iv; in_bit = ib; out_ready = rdy; fn_sel = 2'(fsel);
    #1;
    ev = 0; eb = 0; all_fixed = 1;
    for (int j = 0; j < L; j++) if (!ref_fixed(j, v)) all_fixed = 0;
    if (r_e < L) ev = ref_fixed(r_e, eb);
    check(in_ready == !st, "R1 in_ready", in_ready, !st);
    check(out_valid == ev, "R2 out_valid timing", out_valid, ev);
    if (ev) check(out_bit == eb, "R3 out_bit value", out_bit, eb);
    check(done == (r_e == L), "R7 done", done, r_e == L);
    if (out_valid && rdy && !st) got = (got << 1) | int'(out_bit);
    if (st) begin
      r_k = 0; r_pre = 0; r_e = 0; r_sel = fsel;   // R5
    end else begin
      if (iv && !all_fixed && r_k < N) begin      // R1, R6
        r_pre = 2 * r_pre + int'(ib); r_k++;
      end
      if (ev && rdy) r_e++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state equals start with code 0
    step(0, 0, 0, 0, 0);
    for (int mode = 0; mode < 2; mode++) begin
      for (int f = 0; f < 4; f++) begin
        for (int x = 0; x < (1 << N); x++) begin
          got = 0;
          // R5: bit offered with start is not taken
          step(1, 1, ~x[N-1], 1, f);
          for (int i = N - 1; i >= 0; i--) begin
            step(0, 1, x[i], mode == 0 ? 1'b1 : 1'((x + i) % 3 != 0), f);
          end
          // R6: late bits ignored; R4 stalls resolved here too
          for (int t = 0; t < 8 && r_e < L; t++) step(0, 1, t[0], 1'(t % 2), f);
          step(0, 1, 1, 1, f);
          check(got == ref_mu(f, x), "R8 assembled level", got, ref_mu(f, x));
        end
      end
    end
    // R5: start during an unfinished evaluation restarts it
    got = 0;
    step(1, 0, 0, 1, 1);
    step(0, 1, 1, 0, 1);
    step(1, 0, 0, 1, 2);
    for (int i = N - 1; i >= 0; i--) step(0, 1, 1'(44 >> i), 1, 2);
    step(0, 0, 0, 1, 2);
    check(got == ref_mu(2, 44), "R5 restart level", got, ref_mu(2, 44));
    summary();
    $finish;
  end
endmodule